// File: doc/BRIEF.md
# Grouped-Scan Memory Request Arbiter

This block chooses which of sixteen requesters may use a shared memory port. Only one requester holds the port at a time. A grant stays on until the memory side pulses a completion input. After reset the arbiter runs in a start-up scan mode. This mode does not try to share bandwidth. It only makes sure that every agent that asks is eventually served.

In scan mode a group counter looks at one group of four adjacent agents per clock cycle, in ascending order, and wraps after the last group. Inside the current group, each agent that is requesting is served once, lowest index first. The counter then moves on. A group with nothing pending costs exactly one cycle.

Driving the mode input high selects a plain round-robin over all sixteen agents. The search starts just after the agent that was granted most recently. The mode input is only looked at while no grant is outstanding, so a mode change never cuts a grant short.

Top module: `gba_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, gnt_o is all zeros after that edge. After reset the arbiter is in scan mode with the group counter at the group holding agent 0, and the round-robin pointer treats agent 15 as the last one granted.
- R2: gnt_o never has more than one bit set.
- R3: A grant goes only to an agent that requested it at the edge that issued it. The grant stays unchanged until an edge at which done_i is 1, and it is zero after that edge. A new grant is issued no earlier than the following edge.
- R4: In scan mode (mode_i = 0) each idle clock edge examines one group of four agents: agents 0–3, then 4–7, then 8–11, then 12–15. If agent 15 is the only requester from reset release, gnt_o equals 16'h8000 after the fourth edge and is zero after the first three.
- R5: Within the current group, the lowest-indexed requesting agent not yet served in this visit is granted next. When the grant completes, the same group is examined again. The counter advances only when no unserved requester remains in the group.
- R6: After the group holding agents 12–15, the counter wraps to the group holding agents 0–3.
- R7: In normal mode (mode_i = 1) an idle edge grants the first requesting agent found by searching upward from the most recently granted agent plus one, modulo 16.
- R8: mode_i has no effect while a grant is outstanding. The held grant keeps its value whatever mode_i does.
- R9: A done_i pulse while no grant is outstanding has no effect on gnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 16 | Request level, one bit per agent |
| done_i | input | 1 | Transfer-complete pulse for the outstanding grant |
| mode_i | input | 1 | 0 = scan mode, 1 = round-robin mode |
| gnt_o | output | 16 | One-hot grant, zero when idle |

## Verification
A lone request on agent 15 right after reset exposes the cycle cost of the group walk, and a later lone request on agent 0 shows the wrap. A full group held high tells lowest-first ordering inside a group apart from a counter that advances early. A two-agent pattern at opposite ends of the vector in round-robin mode separates "start after last grant" from a fixed priority. Sparse random request patterns with random completion timing and mode flips, some of them during a grant, are compared each cycle with a bench model. This covers done pulses while idle and requests that drop during a grant.

// File: rtl/gba_pkg.sv
// Package gba_pkg
// Shared types of the grouped-scan arbiter.
// Assumes nothing beyond IEEE 1800-2017.
package gba_pkg;

    // Operating mode as seen on the mode input
    typedef enum logic {
        MODE_SCAN   = 1'b0,
        MODE_ROTATE = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/gba_group_scan.sv
// Module gba_group_scan
// Looks at the requests of the group selected by grp_i, masks the lanes
// already served in this visit and returns the lowest remaining agent.
// Assumes GROUP is a power of two and at least 2, so an agent index is
// {group, lane}.
module gba_group_scan #(
    parameter int AGENTS = 16,
    parameter int GROUP  = 4,
    localparam int NGROUPS = AGENTS / GROUP,
    localparam int IW      = $clog2(AGENTS),
    localparam int GW      = $clog2(NGROUPS),
    localparam int LW      = $clog2(GROUP)
) (
    input  logic [AGENTS-1:0] req_i,
    input  logic [GW-1:0]     grp_i,
    input  logic [GROUP-1:0]  served_i,
    output logic              hit_o,
    output logic [IW-1:0]     idx_o
);

    logic [GROUP-1:0] slice;
    logic [GROUP-1:0] pending;
    logic [LW-1:0]    lane;

    // Gather the request bits of the current group
    always_comb begin
        for (int l = 0; l < GROUP; l++) begin
            slice[l] = req_i[{grp_i, LW'(l)}];
        end
    end

    assign pending = slice & ~served_i;

    // Lowest pending lane wins
    always_comb begin
        lane = '0;
        for (int l = GROUP - 1; l >= 0; l--) begin
            if (pending[l]) lane = LW'(l);
        end
    end

    assign hit_o = |pending;
    assign idx_o = {grp_i, lane};

endmodule

// File: rtl/gba_group_ctr.sv
// Module gba_group_ctr
// Holds the group counter and the mask of lanes served in the current
// visit. advance_i moves to the next group (with wrap) and clears the
// mask; mark_i sets the bit of a finished lane.
// Assumes advance_i and mark_i are never high together.
module gba_group_ctr #(
    parameter int AGENTS = 16,
    parameter int GROUP  = 4,
    localparam int NGROUPS = AGENTS / GROUP,
    localparam int GW      = $clog2(NGROUPS),
    localparam int LW      = $clog2(GROUP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    input  logic             mark_i,
    input  logic [LW-1:0]    mark_lane_i,
    output logic [GW-1:0]    grp_o,
    output logic [GROUP-1:0] served_o
);

    // Group counter: ascending walk, wraps after the last group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_o <= '0;
        end else if (advance_i) begin
            if (grp_o == GW'(NGROUPS - 1)) grp_o <= '0;
            else                           grp_o <= grp_o + 1'b1;
        end
    end

    // Served mask: cleared on advance, one bit set per completed grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_o <= '0;
        end else if (advance_i) begin
            served_o <= '0;
        end else if (mark_i) begin
            served_o[mark_lane_i] <= 1'b1;
        end
    end

endmodule

// File: rtl/gba_rr_pick.sv
// Module gba_rr_pick
// Round-robin choice over all agents: the first requester found when
// searching upward from last_i + 1, wrapping at AGENTS.
// Purely combinational; assumes last_i < AGENTS.
module gba_rr_pick #(
    parameter int AGENTS = 16,
    localparam int IW = $clog2(AGENTS)
) (
    input  logic [AGENTS-1:0] req_i,
    input  logic [IW-1:0]     last_i,
    output logic              hit_o,
    output logic [IW-1:0]     idx_o
);

    // Rotating search, first match kept
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = 1; k <= AGENTS; k++) begin
            int c;
            c = (int'(last_i) + k) % AGENTS;
            if (!hit_o && req_i[c]) begin
                hit_o = 1'b1;
                idx_o = IW'(c);
            end
        end
    end

endmodule

// File: rtl/gba_arbiter.sv
// Module gba_arbiter (top)
// Grants one of AGENTS requesters at a time and holds the grant until
// done_i. mode_i = 0 walks groups of GROUP agents, one group per idle
// cycle; mode_i = 1 uses round-robin over all agents. mode_i is only
// used while idle, so a grant is never cut short.
// Assumes GROUP is a power of two >= 2 dividing AGENTS, and that done_i
// is meaningful only while a grant is on.
module gba_arbiter
    import gba_pkg::*;
#(
    parameter int AGENTS = 16,
    parameter int GROUP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AGENTS-1:0] req_i,
    input  logic              done_i,
    input  logic              mode_i,
    output logic [AGENTS-1:0] gnt_o
);

    localparam int NGROUPS = AGENTS / GROUP;
    localparam int IW      = $clog2(AGENTS);
    localparam int GW      = $clog2(NGROUPS);
    localparam int LW      = $clog2(GROUP);

    arb_mode_e          mode;
    logic               busy_q;
    logic               scan_grant_q;
    logic [IW-1:0]      idx_q;
    logic [IW-1:0]      last_q;
    logic [AGENTS-1:0]  gnt_q;

    logic [GW-1:0]      grp;
    logic [GROUP-1:0]   served;
    logic               scan_hit;
    logic [IW-1:0]      scan_idx;
    logic               rr_hit;
    logic [IW-1:0]      rr_idx;

    logic               start;
    logic [IW-1:0]      pick;
    logic [AGENTS-1:0]  pick_onehot;
    logic               advance;
    logic               mark;

    assign mode = arb_mode_e'(mode_i);

    gba_group_scan #(.AGENTS(AGENTS), .GROUP(GROUP)) u_scan (
        .req_i    (req_i),
        .grp_i    (grp),
        .served_i (served),
        .hit_o    (scan_hit),
        .idx_o    (scan_idx)
    );

    gba_rr_pick #(.AGENTS(AGENTS)) u_rr (
        .req_i  (req_i),
        .last_i (last_q),
        .hit_o  (rr_hit),
        .idx_o  (rr_idx)
    );

    gba_group_ctr #(.AGENTS(AGENTS), .GROUP(GROUP)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (advance),
        .mark_i      (mark),
        .mark_lane_i (idx_q[LW-1:0]),
        .grp_o       (grp),
        .served_o    (served)
    );

    // Idle-cycle decision: which source picks, and whether the group moves
    always_comb begin
        start   = 1'b0;
        pick    = scan_idx;
        advance = 1'b0;
        if (!busy_q) begin
            if (mode == MODE_ROTATE) begin
                start = rr_hit;
                pick  = rr_idx;
            end else begin
                start   = scan_hit;
                advance = !scan_hit;
            end
        end
    end

    // A finished scan-mode grant marks its lane as served
    assign mark = busy_q && done_i && scan_grant_q;

    // Decode the chosen index into a one-hot vector
    for (genvar a = 0; a < AGENTS; a++) begin : g_dec
        assign pick_onehot[a] = (pick == IW'(a));
    end

    // Grant register: issue when idle, hold until done_i
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            scan_grant_q <= 1'b0;
            gnt_q        <= '0;
            idx_q        <= '0;
            last_q       <= IW'(AGENTS - 1);
        end else if (busy_q) begin
            if (done_i) begin
                busy_q <= 1'b0;
                gnt_q  <= '0;
            end
        end else if (start) begin
            busy_q       <= 1'b1;
            gnt_q        <= pick_onehot;
            idx_q        <= pick;
            last_q       <= pick;
            scan_grant_q <= (mode == MODE_SCAN);
        end
    end

    assign gnt_o = gnt_q;

endmodule

// File: rtl/gba_checker.sv
// Module gba_checker
// Port-level properties of the grouped-scan arbiter, bound to every
// instance of gba_arbiter.
module gba_checker #(
    parameter int AGENTS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AGENTS-1:0] req_i,
    input logic              done_i,
    input logic              mode_i,
    input logic [AGENTS-1:0] gnt_o
);

    // R1: reset clears the grant
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> gnt_o == '0);

    // R2: never two grants
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R3: grant held while no completion arrives (also covers R8)
    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !done_i) |=> $stable(gnt_o));

    // R3: completion releases the grant
    assert_grant_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && done_i) |=> gnt_o == '0);

    // R3: a fresh grant belongs to an agent that was requesting
    assert_grant_to_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |=> (gnt_o == '0 || (gnt_o & $past(req_i)) != '0));

    // R9: completion while idle does not create a grant by itself
    assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && done_i && req_i == '0) |=> gnt_o == '0);

endmodule

bind gba_arbiter gba_checker #(.AGENTS(AGENTS)) u_gba_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .done_i (done_i),
    .mode_i (mode_i),
    .gnt_o  (gnt_o)
);

// File: tb/test_gba_arbiter.sv
// Bench for gba_arbiter: directed corner cases, then seeded random
// traffic compared each cycle with a bench model built from the
// requirements.
module test_gba_arbiter;

    localparam int  AGENTS = 16;
    localparam int  GROUP  = 4;
    localparam time PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AGENTS-1:0] req_i = '0;
    logic              done_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [AGENTS-1:0] gnt_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model state
    bit                m_busy;
    bit                m_scan;
    logic [AGENTS-1:0] m_gnt;
    int                m_grp;
    logic [GROUP-1:0]  m_served;
    int                m_idx;
    int                m_last;

    always #(PERIOD/2) clk = ~clk;

    gba_arbiter #(.AGENTS(AGENTS), .GROUP(GROUP)) i_gba_arbiter (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .done_i (done_i),
        .mode_i (mode_i),
        .gnt_o  (gnt_o)
    );

    // Model: next state from current inputs, per the requirements
    task automatic model_edge();
        if (!rst_n) begin
            m_busy = 0; m_scan = 0; m_gnt = '0; m_grp = 0;
            m_served = '0; m_idx = 0; m_last = AGENTS - 1;
        end else if (m_busy) begin
            if (done_i) begin
                m_busy = 0;
                m_gnt  = '0;
                if (m_scan) m_served[m_idx % GROUP] = 1'b1;
            end
        end else if (mode_i) begin
            for (int k = 1; k <= AGENTS; k++) begin
                int c;
                c = (m_last + k) % AGENTS;
                if (!m_busy && req_i[c]) begin
                    m_busy = 1; m_scan = 0; m_idx = c; m_last = c;
                    m_gnt = '0; m_gnt[c] = 1'b1;
                end
            end
        end else begin
            for (int l = 0; l < GROUP; l++) begin
                int c;
                c = m_grp * GROUP + l;
                if (!m_busy && req_i[c] && !m_served[l]) begin
                    m_busy = 1; m_scan = 1; m_idx = c; m_last = c;
                    m_gnt = '0; m_gnt[c] = 1'b1;
                end
            end
            if (!m_busy) begin
                m_grp = (m_grp + 1) % (AGENTS / GROUP);
                m_served = '0;
            end
        end
    endtask

    task automatic chk(input logic [AGENTS-1:0] exp, input string tag);
        n_cmp++;
        if (gnt_o !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt_o=%h expected=%h at %0t", tag, gnt_o, exp, $time);
        end
    endtask

    // One clock: advance model, let the edge pass, compare at negedge
    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(m_gnt, tag);
    endtask

    initial begin : watchdog
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, gnt_o=%h expected=done", gnt_o);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4711));
        @(negedge clk);
        tick("R1"); tick("R1");
        chk('0, "R1");

        // R4: lone agent 15 granted after the fourth edge
        rst_n = 1'b1; req_i = 16'h8000;
        tick("R4"); chk('0, "R4");
        tick("R4"); chk('0, "R4");
        tick("R4"); chk('0, "R4");
        tick("R4"); chk(16'h8000, "R4");

        // R8: mode flips during the grant do nothing
        mode_i = 1'b1; tick("R8"); chk(16'h8000, "R8");
        mode_i = 1'b0; tick("R8"); chk(16'h8000, "R3");

        // R3 and R6: release, then wrap to the first group
        done_i = 1'b1; req_i = 16'h0001;
        tick("R3"); chk('0, "R3");
        done_i = 1'b0;
        tick("R6"); chk('0, "R6");
        tick("R6"); chk(16'h0001, "R6");

        // R5: rest of group 0 served lowest first, agent 0 not repeated
        req_i = 16'h000F;
        for (int b = 1; b < GROUP; b++) begin
            done_i = 1'b1; tick("R5");
            done_i = 1'b0; tick("R5");
            chk(AGENTS'(1) << b, "R5");
        end
        done_i = 1'b1; tick("R5"); done_i = 1'b0;
        tick("R5"); chk('0, "R5");

        // R9: completion pulses while idle
        req_i = '0; done_i = 1'b1;
        tick("R9"); tick("R9"); chk('0, "R9");
        done_i = 1'b0;

        // R7: round-robin from after the last grant, fresh reset
        rst_n = 1'b0; tick("R1");
        rst_n = 1'b1; mode_i = 1'b1; req_i = 16'h8001;
        tick("R7"); chk(16'h0001, "R7");
        done_i = 1'b1; tick("R7"); done_i = 1'b0;
        tick("R7"); chk(16'h8000, "R7");
        done_i = 1'b1; tick("R7"); done_i = 1'b0;
        tick("R7"); chk(16'h0001, "R7");
        done_i = 1'b1; tick("R7"); done_i = 1'b0;

        // Random traffic against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 150 == 0) mode_i = 1'($urandom % 2);
            if ($urandom % 4 == 0) req_i = AGENTS'($urandom & $urandom & $urandom);
            if (gnt_o != '0) done_i = ($urandom % 3 == 0);
            else             done_i = ($urandom % 8 == 0);
            tick(mode_i ? "R7" : "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule